// File: doc/BRIEF.md
# Segment Access Guard with Privilege Mode

This block sits beside a processor's memory port and decides, in the same cycle, whether each data or instruction access may proceed. It keeps two pieces of state. The first is a single privilege bit. The second is a protection mask with one bit for each of sixteen equal slices of the 64K-word address space. The top four address bits pick the slice, and that slice's mask bit grants or refuses the access. While the privilege bit is high, the mask is bypassed and every access is granted.

Trap execution sets the privilege bit and return-from-trap clears it. Only code that is already privileged can reload the mask. The guard drives three outputs. The grant tells the memory system that the access may go ahead. The violation output doubles as the exception request. The gated write enable stays low whenever a write is refused. All state changes happen on the rising clock edge and only in cycles where the global write enable is high, which matches the other state elements of the processor.

Top module: `mem_guard`

## Requirements
- R1: Synchronous reset (rst high at a rising edge) sets the privilege bit to 1 and every mask bit to 1, so after reset every access is granted, and it is still granted after leaving privileged mode until the mask is reloaded.
- R2: In user mode (privilege bit 0), a valid access whose address bits [15:12] select a mask bit of 1 is granted (accAllow=1, accViolation=0).
- R3: In user mode, a valid access whose selected mask bit is 0 is refused: accAllow=0 and accViolation=1, in the same cycle.
- R4: In privileged mode, every valid access is granted whatever the mask holds, and accViolation stays 0.
- R5: memWe equals accValid AND accWrite AND accAllow, so a refused write never reaches memory.
- R6: At a rising edge with globalWe=1, trapExec=1 sets the privilege bit. rtnExec=1 with trapExec=0 clears it. When both are 1 in the same cycle, the trap wins and the bit ends up set.
- R7: mprWrEn=1 loads mprWrData into the mask at the edge only while privileged. In user mode the write is ignored (the mask is unchanged) and accViolation is raised in that cycle.
- R8: When globalWe=0, neither the privilege bit nor the mask changes at the clock edge, whatever the other inputs are.
- R9: With accValid=0 and mprWrEn=0, accAllow, accViolation and memWe are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| globalWe | input | 1 | Global state-update enable |
| trapExec | input | 1 | A trap instruction executes this cycle |
| rtnExec | input | 1 | A return-from-trap executes this cycle |
| mprWrEn | input | 1 | Request to load the protection mask |
| mprWrData | input | 16 | New mask value, bit i guards slice i |
| accValid | input | 1 | A memory access is presented this cycle |
| accAddr | input | 16 | Word address of the access |
| accWrite | input | 1 | The access is a write |
| accAllow | output | 1 | Access granted |
| accViolation | output | 1 | Protection violation; exception request |
| memWe | output | 1 | Write enable passed on to memory |

## Verification
A behavioural reference model in the bench predicts the three outputs before every clock edge. In user mode, a sweep of all sixteen slices is run against a mask with mixed bits, in both read and write form. This shows that the right address bits select the slice, and that a refused write drops memWe. The same denied slices are then accessed in privileged mode, which tells bypass apart from a real grant. Mask writes attempted in user mode, trap and return arriving in the same cycle, and edges with globalWe low are each followed by probe accesses that expose the stored state. A long pseudo-random stream then mixes every input against the model.

// File: rtl/mem_guard_pkg.sv
package mem_guard_pkg;

  // Strobes passed from the privilege control to the protection datapath
  typedef struct packed {
    logic privileged;  // current privilege state
    logic mprLoad;     // load the mask at this edge
    logic wrDenied;    // user-mode mask write attempt
  } guard_strobe_t;

endpackage

// File: rtl/mem_guard_ctrl.sv
module mem_guard_ctrl
  import mem_guard_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          globalWe,
  input  logic          trapExec,
  input  logic          rtnExec,
  input  logic          mprWrEn,
  output guard_strobe_t strobe
);

  logic privQ;

  // Trap entry has priority over trap exit
  always_ff @(posedge clk) begin
    if (rst) begin
      privQ <= 1'b1;
    end else if (globalWe) begin
      if (trapExec) begin
        privQ <= 1'b1;
      end else if (rtnExec) begin
        privQ <= 1'b0;
      end
    end
  end

  always_comb begin
    strobe.privileged = privQ;
    strobe.mprLoad    = globalWe & mprWrEn & privQ;
    strobe.wrDenied   = mprWrEn & ~privQ;
  end

  // R6: trap execution enters privileged mode
  a_r6_trap_sets: assert property (@(posedge clk) disable iff (rst)
    (globalWe && trapExec) |=> strobe.privileged);

  // R6: return-from-trap alone leaves privileged mode
  a_r6_rtn_clears: assert property (@(posedge clk) disable iff (rst)
    (globalWe && rtnExec && !trapExec) |=> !strobe.privileged);

  // R8: no privilege change without the global write enable
  a_r8_priv_hold: assert property (@(posedge clk) disable iff (rst)
    !globalWe |=> $stable(strobe.privileged));

endmodule

// File: rtl/mem_guard_dp.sv
module mem_guard_dp
  import mem_guard_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int SEG_BITS = 4,
  localparam int NUM_SEG = 1 << SEG_BITS
) (
  input  logic               clk,
  input  logic               rst,
  input  guard_strobe_t      strobe,
  input  logic [NUM_SEG-1:0] mprWrData,
  input  logic               accValid,
  input  logic [ADDR_W-1:0]  accAddr,
  input  logic               accWrite,
  output logic               accAllow,
  output logic               accViolation,
  output logic               memWe
);

  logic [NUM_SEG-1:0]  mprQ;
  logic [SEG_BITS-1:0] segIdx;
  logic                segOk;

  // One state bit per address slice
  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    logic bitQ;
    always_ff @(posedge clk) begin
      if (rst) begin
        bitQ <= 1'b1;
      end else if (strobe.mprLoad) begin
        bitQ <= mprWrData[g];
      end
    end
    assign mprQ[g] = bitQ;
  end

  always_comb begin
    segIdx       = accAddr[ADDR_W-1 -: SEG_BITS];
    segOk        = mprQ[segIdx];
    accAllow     = accValid & (strobe.privileged | segOk);
    accViolation = (accValid & ~strobe.privileged & ~segOk) | strobe.wrDenied;
    memWe        = accWrite & accAllow;
  end

  // R3: a refused user-mode access raises the violation
  a_r3_refused_flags: assert property (@(posedge clk) disable iff (rst)
    (accValid && !strobe.privileged && !accAllow) |-> accViolation);

  // R4: privileged accesses never violate
  a_r4_priv_clean: assert property (@(posedge clk) disable iff (rst)
    strobe.privileged |-> !accViolation);

  // R5: memory write only on a granted access
  a_r5_we_granted: assert property (@(posedge clk) disable iff (rst)
    memWe |-> (accAllow && accValid && accWrite));

  // R7: user-mode mask writes leave the mask untouched
  a_r7_user_write_ignored: assert property (@(posedge clk) disable iff (rst)
    strobe.wrDenied |=> $stable(mprQ));

endmodule

// File: rtl/mem_guard.sv
module mem_guard
  import mem_guard_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int SEG_BITS = 4,
  localparam int NUM_SEG = 1 << SEG_BITS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               globalWe,
  input  logic               trapExec,
  input  logic               rtnExec,
  input  logic               mprWrEn,
  input  logic [NUM_SEG-1:0] mprWrData,
  input  logic               accValid,
  input  logic [ADDR_W-1:0]  accAddr,
  input  logic               accWrite,
  output logic               accAllow,
  output logic               accViolation,
  output logic               memWe
);

  guard_strobe_t strobe;

  mem_guard_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .globalWe (globalWe),
    .trapExec (trapExec),
    .rtnExec  (rtnExec),
    .mprWrEn  (mprWrEn),
    .strobe   (strobe)
  );

  mem_guard_dp #(
    .ADDR_W   (ADDR_W),
    .SEG_BITS (SEG_BITS)
  ) u_dp (
    .clk          (clk),
    .rst          (rst),
    .strobe       (strobe),
    .mprWrData    (mprWrData),
    .accValid     (accValid),
    .accAddr      (accAddr),
    .accWrite     (accWrite),
    .accAllow     (accAllow),
    .accViolation (accViolation),
    .memWe        (memWe)
  );

  // R8: mask changes only through a privileged, enabled load
  a_r8_mask_hold: assert property (@(posedge clk) disable iff (rst)
    (!globalWe || !mprWrEn) |=> $stable(u_dp.mprQ));

endmodule

// File: tb/mem_guard_bench.sv
module mem_guard_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        globalWe = 1'b0;
  logic        trapExec = 1'b0;
  logic        rtnExec = 1'b0;
  logic        mprWrEn = 1'b0;
  logic [15:0] mprWrData = '0;
  logic        accValid = 1'b0;
  logic [15:0] accAddr = '0;
  logic        accWrite = 1'b0;
  logic        accAllow;
  logic        accViolation;
  logic        memWe;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // Reference state
  bit          refPriv;
  logic [15:0] refMask;

  always #4 clk = ~clk;

  mem_guard u_mem_guard (
    .clk          (clk),
    .rst          (rst),
    .globalWe     (globalWe),
    .trapExec     (trapExec),
    .rtnExec      (rtnExec),
    .mprWrEn      (mprWrEn),
    .mprWrData    (mprWrData),
    .accValid     (accValid),
    .accAddr      (accAddr),
    .accWrite     (accWrite),
    .accAllow     (accAllow),
    .accViolation (accViolation),
    .memWe        (memWe)
  );

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  // One cycle: drive at negedge, compare before posedge, advance model
  task automatic step(input string tag, input logic v, input logic [15:0] a,
                      input logic w, input logic gwe, input logic tr,
                      input logic rt, input logic mw, input logic [15:0] md);
    bit segBit;
    bit eAllow;
    bit eViol;
    bit eWe;
    @(negedge clk);
    accValid = v; accAddr = a; accWrite = w; globalWe = gwe;
    trapExec = tr; rtnExec = rt; mprWrEn = mw; mprWrData = md;
    #2;
    segBit = refMask[a / 4096];
    eAllow = v && (refPriv || segBit);
    eViol  = (v && !refPriv && !segBit) || (mw && !refPriv);
    eWe    = v && w && eAllow;
    check(tag, "accAllow", accAllow, eAllow);
    check(tag, "accViolation", accViolation, eViol);
    check(tag, "memWe", memWe, eWe);
    @(posedge clk);
    if (gwe) begin
      if (mw && refPriv) refMask = md;
      if (tr) refPriv = 1'b1;
      else if (rt) refPriv = 1'b0;
    end
  endtask

  task automatic probe(input string tag, input logic [15:0] a, input logic w);
    step(tag, 1'b1, a, w, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R1 watchdog actual=expired expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(posedge clk);
    refPriv = 1'b1;
    refMask = 16'hFFFF;
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state is privileged with full mask
    probe("R1", 16'h0000, 1'b1);
    probe("R1", 16'hF123, 1'b0);
    step("R1", 1'b0, 16'h0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0);
    for (int s = 0; s < 16; s++) probe("R1", 16'(s * 4096 + 7), 1'b1);

    // R7: privileged load after re-entering via trap
    step("R6", 1'b0, 16'h0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0);
    step("R7", 1'b0, 16'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 16'hA5C3);
    // R4: privileged access to slices the mask denies
    for (int s = 0; s < 16; s++) probe("R4", 16'(s * 4096 + 16'h0AB), 1'b1);
    step("R6", 1'b0, 16'h0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0);

    // R2 R3 R5: user-mode sweep, reads and writes
    for (int s = 0; s < 16; s++) probe("R2", 16'(s * 4096 + 16'h0FFF), 1'b0);
    for (int s = 0; s < 16; s++) probe("R3", 16'(s * 4096), 1'b1);
    for (int s = 0; s < 16; s++) probe("R5", 16'(s * 4096 + 16'h0800), 1'b1);

    // R7: user-mode write ignored and flagged
    step("R7", 1'b0, 16'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 16'hFFFF);
    step("R7", 1'b1, 16'h1000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0000);
    for (int s = 0; s < 16; s++) probe("R7", 16'(s * 4096 + 3), 1'b1);

    // R8: trap and mask load without global enable are held
    step("R8", 1'b0, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0);
    probe("R8", 16'h2000, 1'b1);
    step("R6", 1'b0, 16'h0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0);
    step("R8", 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0000);
    step("R6", 1'b0, 16'h0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0);
    for (int s = 0; s < 16; s++) probe("R8", 16'(s * 4096 + 9), 1'b0);

    // R6: trap wins over simultaneous return
    step("R6", 1'b0, 16'h0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0);
    probe("R6", 16'h2000, 1'b1);
    step("R6", 1'b0, 16'h0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0);
    probe("R6", 16'h3000, 1'b1);
    step("R6", 1'b0, 16'h0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0);
    probe("R6", 16'h2000, 1'b1);

    // R9: idle cycles
    step("R9", 1'b0, 16'h2000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
    step("R9", 1'b0, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0);

    // R5: mixed pseudo-random stream
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step("R5", lfsr[0], {lfsr[3:0], lfsr[15:4]}, lfsr[1], lfsr[2] | lfsr[5],
           lfsr[7:6] == 2'b11, lfsr[9:8] == 2'b11, lfsr[11:10] == 2'b11,
           {lfsr[7:0], lfsr[15:8]});
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule